// File: doc/BRIEF.md
# Handshake Bus Event Interrupt Unit

This unit watches the control lines of a simple shared byte bus and turns line activity into host interrupts. Two active-high inputs from the bus, the bus-available line and the handshake line, each pass through a filter that accepts a new level only after it has held for two consecutive clock edges. The filtered bus-available level, together with a write-busy and a receive-phase signal from neighbouring transmit and receive logic, feeds edge detectors. Those edges set four sticky event flags.

The host sees an 8-bit status word and an 8-bit control word. The status word carries the four sticky flags and four live levels. The control word holds one interrupt enable for each flag. A single registered, level-sensitive interrupt output is high while any enabled flag is set. Reading the status word acknowledges everything at once: it clears all four flags and so drops the interrupt. An event that arrives in the same cycle as that read is kept.

Top module: `hbus_evt_irq`

## Requirements
- R1: A filtered line (bus-available or handshake) changes only after its raw input has shown the new level at two consecutive rising clock edges. A level held for one edge only is ignored.
- R2: Status bits 3, 2, 1 and 0 carry, in that order, the filtered bus-available level, the filtered handshake level, the registered write-busy level and the registered receive-phase level.
- R3: A rising edge of filtered bus-available sets the bus-on flag (status bit 6). A falling edge sets the bus-off flag (status bit 7).
- R4: A falling edge of registered write-busy sets the write-done flag (status bit 4). A falling edge of registered receive-phase sets the read-done flag (status bit 5).
- R5: A cycle with `stat_re` high clears all four flags at the next clock edge, and the interrupt goes low in that same edge.
- R6: `irq` is high exactly when some flag is set and its enable is set. Control bit 0 enables write-done, bit 1 read-done, bit 2 bus-on and bit 3 bus-off.
- R7: Reset gives a status word of 0xFF, a control word of 0x00 and `irq` low.
- R8: When a flag's event and a status read fall in the same cycle, the flag ends up set.
- R9: Control bits 7 to 4 are stored and read back on `ctrl_rdata`, and they have no effect on `irq`.
- R10: Once high, `irq` stays high until a status read, even after the event inputs have gone quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bav_in | input | 1 | Raw bus-available line |
| hsk_in | input | 1 | Raw handshake line |
| wr_busy_in | input | 1 | Write-busy level from the transmit logic |
| rd_phase_in | input | 1 | Receive-phase level from the receive logic |
| ctrl_we | input | 1 | Writes `ctrl_wdata` into the control word |
| ctrl_wdata | input | 8 | Control write data |
| ctrl_rdata | output | 8 | Current control word |
| stat_re | input | 1 | Status read strobe; clears the flags |
| stat_rdata | output | 8 | Current status word |
| irq | output | 1 | Level interrupt request |

## Verification
The bench aims at the pulse that lasts one edge on the bus-available line. A filter that passes it would show a level change and set a flag that should never appear. It puts a status read in the very cycle a write-busy fall is detected. A design where the clear wins would lose that write-done event and leave `irq` low. It also keeps `irq` waiting for several quiet cycles before the acknowledge, and it writes only the upper control bits. This exposes an interrupt that decays by itself, or enable bits decoded at the wrong positions.

// File: rtl/hbus_evt_pkg.sv
package hbus_evt_pkg;

    localparam int REG_W     = 8;
    localparam int NUM_FLAGS = 4;

    // flag index == control enable bit == (status bit - NUM_FLAGS)
    localparam int FLG_WR_DONE = 0;
    localparam int FLG_RD_DONE = 1;
    localparam int FLG_BUS_ON  = 2;
    localparam int FLG_BUS_OFF = 3;

    // level positions in the status word
    localparam int LVL_RD   = 0;
    localparam int LVL_BUSY = 1;
    localparam int LVL_HSK  = 2;
    localparam int LVL_BAV  = 3;

    typedef struct packed {
        logic                 busy;
        logic                 rd;
        logic [NUM_FLAGS-1:0] flags;
        logic [REG_W-1:0]     ctrl;
        logic                 irq;
    } evt_state_t;

endpackage

// File: rtl/hbus_glitch_filter.sv
module hbus_glitch_filter #(
    parameter int             WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] filt
);

    typedef struct packed {
        logic [WIDTH-1:0] smp;
        logic [WIDTH-1:0] filt;
    } flt_state_t;

    flt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.smp = raw;
    end

    // each lane accepts a level only when it matches the previous sample
    for (genvar g = 0; g < WIDTH; g++) begin : g_lane
        logic agree;
        assign agree = (raw[g] == st_q.smp[g]);
        always_comb begin
            st_d_lane[g] = agree ? raw[g] : st_q.filt[g];
        end
    end

    logic [WIDTH-1:0] st_d_lane;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.smp  <= RST_VAL;
            st_q.filt <= RST_VAL;
        end else begin
            st_q.smp  <= st_d.smp;
            st_q.filt <= st_d_lane;
        end
    end

    assign filt = st_q.filt;

    // R1: a filtered bit only moves to a level seen on raw at the two prior edges
    a_r1_two_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.filt ^ $past(st_q.filt)) &
         ((st_q.filt ^ $past(raw)) | (st_q.filt ^ $past(raw, 2)))) == '0);

endmodule

// File: rtl/hbus_edge_tracker.sv
module hbus_edge_tracker #(
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= prev_d;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_edge
        assign rise[g] =  sig[g] & ~prev_q[g];
        assign fall[g] = ~sig[g] &  prev_q[g];
    end

endmodule

// File: rtl/hbus_evt_irq.sv
module hbus_evt_irq
    import hbus_evt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bav_in,
    input  logic             hsk_in,
    input  logic             wr_busy_in,
    input  logic             rd_phase_in,
    input  logic             ctrl_we,
    input  logic [REG_W-1:0] ctrl_wdata,
    output logic [REG_W-1:0] ctrl_rdata,
    input  logic             stat_re,
    output logic [REG_W-1:0] stat_rdata,
    output logic             irq
);

    localparam int LINES = 2;   // bav, hsk
    localparam int EDGES = 3;   // busy, rd, bav

    evt_state_t st_d, st_q;

    logic [LINES-1:0] filt;
    logic             bav_f, hsk_f;
    logic [EDGES-1:0] rise_v, fall_v;
    logic [NUM_FLAGS-1:0] set_evt;
    logic             unused_rise;

    hbus_glitch_filter #(
        .WIDTH   (LINES),
        .RST_VAL ('1)
    ) i_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({bav_in, hsk_in}),
        .filt  (filt)
    );

    assign bav_f = filt[1];
    assign hsk_f = filt[0];

    hbus_edge_tracker #(
        .WIDTH   (EDGES),
        .RST_VAL ('1)
    ) i_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   ({bav_f, st_q.rd, st_q.busy}),
        .rise  (rise_v),
        .fall  (fall_v)
    );

    assign unused_rise = ^rise_v[1:0];

    always_comb begin
        set_evt              = '0;
        set_evt[FLG_WR_DONE] = fall_v[0];
        set_evt[FLG_RD_DONE] = fall_v[1];
        set_evt[FLG_BUS_ON]  = rise_v[2];
        set_evt[FLG_BUS_OFF] = fall_v[2];
    end

    always_comb begin
        st_d       = st_q;
        st_d.busy  = wr_busy_in;
        st_d.rd    = rd_phase_in;
        // a new event wins over the acknowledge of the same cycle
        st_d.flags = (stat_re ? '0 : st_q.flags) | set_evt;
        if (ctrl_we) st_d.ctrl = ctrl_wdata;
        st_d.irq   = |(st_d.flags & st_d.ctrl[NUM_FLAGS-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.busy  <= 1'b1;
            st_q.rd    <= 1'b1;
            st_q.flags <= '1;
            st_q.ctrl  <= '0;
            st_q.irq   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        stat_rdata                     = '0;
        stat_rdata[REG_W-1:NUM_FLAGS]  = st_q.flags;
        stat_rdata[LVL_BAV]            = bav_f;
        stat_rdata[LVL_HSK]            = hsk_f;
        stat_rdata[LVL_BUSY]           = st_q.busy;
        stat_rdata[LVL_RD]             = st_q.rd;
    end

    assign ctrl_rdata = st_q.ctrl;
    assign irq        = st_q.irq;

    // R3: bus-on flag only newly appears after filtered bav rose
    a_r3_on_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flags[FLG_BUS_ON]) |-> ($past(bav_f) && !$past(bav_f, 2)));

    // R3: bus-off flag only newly appears after filtered bav fell
    a_r3_off_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flags[FLG_BUS_OFF]) |-> (!$past(bav_f) && $past(bav_f, 2)));

    // R4: write-done flag only newly appears after busy fell
    a_r4_wr_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.flags[FLG_WR_DONE]) |-> (!$past(st_q.busy) && $past(st_q.busy, 2)));

    // R5: a quiet read leaves no flag and no interrupt
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_re) && ($past(set_evt) == '0)) |-> (st_q.flags == '0 && !irq));

    // R6: interrupt always has an enabled cause visible on the ports
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((stat_rdata[REG_W-1:NUM_FLAGS] & ctrl_rdata[NUM_FLAGS-1:0]) != '0));

    // R10: without a read or enable change the interrupt holds
    a_r10_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_re && !ctrl_we) |=> irq);

endmodule

// File: tb/test_hbus_evt_irq.sv
module test_hbus_evt_irq;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bav_in = 1'b1, hsk_in = 1'b1, wr_busy_in = 1'b1, rd_phase_in = 1'b1;
    logic       ctrl_we = 1'b0, stat_re = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_rdata, stat_rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hbus_evt_irq i_hbus_evt_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .bav_in      (bav_in),
        .hsk_in      (hsk_in),
        .wr_busy_in  (wr_busy_in),
        .rd_phase_in (rd_phase_in),
        .ctrl_we     (ctrl_we),
        .ctrl_wdata  (ctrl_wdata),
        .ctrl_rdata  (ctrl_rdata),
        .stat_re     (stat_re),
        .stat_rdata  (stat_rdata),
        .irq         (irq)
    );

    // reference model written from the requirements
    logic       m_s_bav, m_s_hsk, m_bav, m_hsk, m_bav_prev;
    logic       m_busy, m_busy_prev, m_rd, m_rd_prev;
    logic [3:0] m_flags;
    logic [7:0] m_ctrl;
    logic       m_irq;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_s_bav, m_s_hsk, m_bav, m_hsk, m_bav_prev} <= '1;
            {m_busy, m_busy_prev, m_rd, m_rd_prev}        <= '1;
            m_flags <= 4'hF;
            m_ctrl  <= 8'h00;
            m_irq   <= 1'b0;
        end else begin
            logic [3:0] ev, nf;
            logic [7:0] nc;
            m_s_bav <= bav_in;
            m_s_hsk <= hsk_in;
            if (bav_in == m_s_bav) m_bav <= bav_in;
            if (hsk_in == m_s_hsk) m_hsk <= hsk_in;
            m_bav_prev  <= m_bav;
            m_busy      <= wr_busy_in;
            m_busy_prev <= m_busy;
            m_rd        <= rd_phase_in;
            m_rd_prev   <= m_rd;
            ev = {~m_bav & m_bav_prev, m_bav & ~m_bav_prev,
                  ~m_rd & m_rd_prev, ~m_busy & m_busy_prev};
            nf = (stat_re ? 4'h0 : m_flags) | ev;
            nc = ctrl_we ? ctrl_wdata : m_ctrl;
            m_flags <= nf;
            m_ctrl  <= nc;
            m_irq   <= |(nf & nc[3:0]);
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // {bav, hsk, busy, rd, re, we, wdata}
    localparam logic [13:0] VECS [NVEC] = '{
        14'b0_1_1_1_0_1_00001111, 14'b0_1_1_1_0_0_00000000,
        14'b0_1_1_1_0_0_00000000, 14'b0_1_1_1_0_0_00000000,
        14'b0_1_1_1_1_0_00000000, 14'b0_1_1_1_0_0_00000000,
        14'b1_1_1_1_0_0_00000000, 14'b0_1_1_1_0_0_00000000,
        14'b1_0_1_1_0_0_00000000, 14'b1_0_1_1_0_0_00000000,
        14'b1_0_1_1_0_0_00000000, 14'b1_0_0_1_1_0_00000000,
        14'b1_1_0_0_0_0_00000000, 14'b1_1_0_0_0_0_00000000,
        14'b1_1_0_0_1_1_00000010, 14'b1_1_1_1_0_0_00000000,
        14'b1_1_1_0_0_0_00000000, 14'b1_1_1_0_0_0_00000000,
        14'b1_1_1_0_0_0_00000000, 14'b1_1_1_1_1_1_00000100,
        14'b0_1_1_1_0_0_00000000, 14'b0_0_1_1_0_0_00000000,
        14'b0_1_1_1_0_0_00000000, 14'b0_1_0_1_0_0_00000000,
        14'b0_1_0_1_0_0_00000000, 14'b0_1_0_1_1_1_00001000,
        14'b1_1_0_1_0_0_00000000, 14'b1_1_0_1_0_0_00000000,
        14'b1_1_1_1_0_0_00000000, 14'b1_1_1_1_1_0_00000000
    };

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R7: reset values
        check("R7 status", stat_rdata, 8'hFF);
        check("R7 control", ctrl_rdata, 8'h00);
        check("R7 irq", {7'd0, irq}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            {bav_in, hsk_in, wr_busy_in, rd_phase_in, stat_re, ctrl_we, ctrl_wdata} = VECS[i];
            tick(1);
            check("R1 R2 levels", {4'h0, stat_rdata[3:0]}, {4'h0, m_bav, m_hsk, m_busy, m_rd});
            check("R3 R4 R5 R8 flags", {4'h0, stat_rdata[7:4]}, {4'h0, m_flags});
            check("R6 R10 irq", {7'd0, irq}, {7'd0, m_irq});
            check("R9 control", ctrl_rdata, m_ctrl);
        end

        // directed: fresh reset with idle-high inputs
        {bav_in, hsk_in, wr_busy_in, rd_phase_in, stat_re, ctrl_we} = 6'b111100;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
        check("R7 status again", stat_rdata, 8'hFF);

        // R9: upper control bits stored but inert
        ctrl_we = 1'b1; ctrl_wdata = 8'hF0;
        tick(1);
        ctrl_we = 1'b0;
        tick(1);
        check("R9 readback", ctrl_rdata, 8'hF0);
        check("R9 no irq", {7'd0, irq}, 8'h00);

        // R5: read clears flags
        stat_re = 1'b1;
        tick(1);
        stat_re = 1'b0;
        check("R5 cleared", stat_rdata, 8'h0F);

        // R1: one-edge glitch on bav is ignored
        bav_in = 1'b0;
        tick(1);
        bav_in = 1'b1;
        tick(3);
        check("R1 glitch level", stat_rdata, 8'h0F);

        // R1/R3: held low for two edges passes, then bus-off flag
        bav_in = 1'b0;
        tick(3);
        check("R1 R3 bus off", stat_rdata, 8'h87);
        ctrl_we = 1'b1; ctrl_wdata = 8'h08;
        tick(1);
        ctrl_we = 1'b0;
        check("R6 irq on", {7'd0, irq}, 8'h01);
        tick(4);
        check("R10 irq held", {7'd0, irq}, 8'h01);
        stat_re = 1'b1;
        tick(1);
        stat_re = 1'b0;
        check("R5 irq dropped", {7'd0, irq}, 8'h00);
        check("R5 flags dropped", stat_rdata, 8'h07);

        // R8: event in the read cycle survives
        ctrl_we = 1'b1; ctrl_wdata = 8'h01;
        tick(1);
        ctrl_we = 1'b0;
        wr_busy_in = 1'b0;
        tick(1);
        stat_re = 1'b1;
        tick(1);
        stat_re = 1'b0;
        check("R8 wr done kept", stat_rdata, 8'h15);
        check("R8 irq kept", {7'd0, irq}, 8'h01);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule